// File: doc/BRIEF.md
# Reset and Wake Controller

This block decides, every clock cycle, which of several reset or wake sources is in charge of a small processor core. The sources are a power-on indication, a brown-out detect level, an asynchronous active-low external reset pin, a watchdog expiry strobe and the core's sleep state. From them it drives one active-low system reset for the general register class, a one-cycle wake pulse that lets a sleeping core resume without a reset, and three status flags that software reads to learn what happened: time-out, power-down and brown-out.

The external pin is synchronized and then filtered by a run-length counter, so short glitches cannot reset the core. A watchdog expiry acts differently depending on the core's state. While the core runs, it resets the core. While the core sleeps, it wakes the core. Registers that must survive every reset kind take no reset from this block. Software strobes for the sleep instruction, the watchdog clear and the brown-out flag write also update the flags, at a lower priority than any hardware event.

Top module: `rst_wake_ctrl`

## Requirements
- R1: While `powerOn` is high, `sysRstN` is low immediately, with no clock edge needed. At the first clock edge, the time-out, power-down and brown-out flags are all set to 1.
- R2: While `brownOut` is high (and `powerOn` is low), `sysRstN` is low immediately. The flags become time-out 1, power-down 1 and brown-out 0.
- R3: The external pin is passed through a two-flop synchronizer. It causes a reset only after FILT_LEN consecutive low samples (default 4). Any high sample restarts the count. A low pulse of FILT_LEN-1 cycles leaves `sysRstN` high and all flags unchanged.
- R4: An accepted external reset while `sleeping` is 0 drives `sysRstN` low. It leaves the time-out and power-down flags unchanged.
- R5: An accepted external reset while `sleeping` is 1 drives `sysRstN` low. It sets time-out to 1 and power-down to 0, and gives no wake pulse.
- R6: A `wdtExpire` strobe while `sleeping` is 0 drives `sysRstN` low after the next clock edge. It sets time-out to 0 and power-down to 1.
- R7: A `wdtExpire` strobe while `sleeping` is 1 does not reset the core. `wakePulse` is high for exactly the one cycle after that edge, and the flags become time-out 0 and power-down 0.
- R8: `sysRstN` rises at the second clock edge after the last active source has cleared.
- R9: A `sleepExec` strobe clears power-down. A `wdtClear` strobe sets both time-out and power-down to 1.
- R10: The brown-out flag goes back to 1 only on a `borSetWr` strobe or on power-on. Sleep and watchdog-clear strobes do not change it.
- R11: When several sources are active in the same cycle, the priority is power-on, then brown-out, then the external pin, then the watchdog, then the software strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| powerOn | input | 1 | Power-on indication, active high, asynchronous |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| wdtExpire | input | 1 | One-cycle watchdog timeout strobe |
| brownOut | input | 1 | Brown-out detect level, active high, asynchronous |
| sleeping | input | 1 | Core is in sleep state |
| sleepExec | input | 1 | Strobe: core executed a sleep instruction |
| wdtClear | input | 1 | Strobe: core cleared the watchdog |
| borSetWr | input | 1 | Strobe: software writes 1 to the brown-out flag |
| sysRstN | output | 1 | Active-low reset for the general register class |
| wakePulse | output | 1 | One-cycle wake-from-sleep pulse |
| toFlag | output | 1 | Time-out status flag |
| pdFlag | output | 1 | Power-down status flag |
| borFlag | output | 1 | Brown-out status flag (0 means a brown-out occurred) |

## Verification
A filter counter stuck at the wrong value shows up at `sysRstN` in one of two ways: a pulse one cycle too short resets the core, or a pulse of the full width does not, and either is visible a few cycles after the pin rises. A wrong priority decision or a wrong flag encoding is a wrong time-out, power-down or brown-out value in the cycle after the event. Each such value is compared once the reset has released. A release pipeline that is too short or too long moves the rising edge of `sysRstN` by a cycle, so it is checked edge by edge after each source clears.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  // Strobes from the priority decoder to the datapath
  typedef struct packed {
    logic asyncRst;     // power-on or brown-out level present
    logic syncRst;      // accepted pin reset or running watchdog reset
    logic setPor;       // flags to power-on values
    logic setBor;       // flags to brown-out values
    logic setExtSleep;  // pin reset that arrived during sleep
    logic setWdtRun;    // watchdog reset while running
    logic setWdtWake;   // watchdog wake from sleep
    logic doClrWdt;     // software cleared the watchdog
    logic doSleep;      // software entered sleep
    logic doBorSet;     // software re-arms brown-out flag
  } rwc_ctl_t;

endpackage

// File: rtl/rwc_pin_filter.sv
module rwc_pin_filter #(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic pinN,
  output logic pinLow
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [CW-1:0]          runCnt;
  logic                   syncOut;

  assign syncOut = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or posedge clr) begin
    if (clr) syncReg <= '1;
    else     syncReg <= {syncReg[SYNC_STAGES-2:0], pinN};
  end

  // Count consecutive low samples, saturating at the limit
  always_ff @(posedge clk or posedge clr) begin
    if (clr)                  runCnt <= '0;
    else if (syncOut)         runCnt <= '0;
    else if (runCnt != LIMIT) runCnt <= runCnt + 1'b1;
  end

  assign pinLow = (runCnt == LIMIT);
endmodule

// File: rtl/rwc_ctrl.sv
module rwc_ctrl
  import rwc_pkg::*;
(
  input  logic     powerOn,
  input  logic     brownOut,
  input  logic     extLow,
  input  logic     wdtExpire,
  input  logic     sleeping,
  input  logic     sleepExec,
  input  logic     wdtClear,
  input  logic     borSetWr,
  output rwc_ctl_t ctl
);
  always_comb begin
    ctl          = '0;
    ctl.asyncRst = powerOn | brownOut;
    if (powerOn) begin
      ctl.setPor = 1'b1;
    end else if (brownOut) begin
      ctl.setBor = 1'b1;
    end else begin
      ctl.doBorSet = borSetWr;
      if (extLow) begin
        ctl.syncRst     = 1'b1;
        ctl.setExtSleep = sleeping;
      end else if (wdtExpire) begin
        if (sleeping) begin
          ctl.setWdtWake = 1'b1;
        end else begin
          ctl.syncRst   = 1'b1;
          ctl.setWdtRun = 1'b1;
        end
      end else if (wdtClear) begin
        ctl.doClrWdt = 1'b1;
      end else if (sleepExec) begin
        ctl.doSleep = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rwc_datapath.sv
module rwc_datapath
  import rwc_pkg::*;
#(
  parameter int RELEASE_EDGES = 2
) (
  input  logic     clk,
  input  rwc_ctl_t ctl,
  output logic     sysRstN,
  output logic     wakePulse,
  output logic     toFlag,
  output logic     pdFlag,
  output logic     borFlag
);
  localparam int SW = RELEASE_EDGES;

  logic [SW-1:0] relStage;

  // Asynchronous assert, synchronous release through SW stages
  always_ff @(posedge clk or posedge ctl.asyncRst) begin
    if (ctl.asyncRst)    relStage <= '0;
    else if (ctl.syncRst) relStage <= '0;
    else                 relStage <= {relStage[SW-2:0], 1'b1};
  end
  assign sysRstN = relStage[SW-1];

  always_ff @(posedge clk or posedge ctl.asyncRst) begin
    if (ctl.asyncRst) wakePulse <= 1'b0;
    else              wakePulse <= ctl.setWdtWake;
  end

  // Status flags belong to the power-on-only class: updated by strobes
  always_ff @(posedge clk) begin
    if (ctl.setPor) begin
      toFlag <= 1'b1; pdFlag <= 1'b1; borFlag <= 1'b1;
    end else if (ctl.setBor) begin
      toFlag <= 1'b1; pdFlag <= 1'b1; borFlag <= 1'b0;
    end else begin
      if (ctl.doBorSet) borFlag <= 1'b1;
      if (ctl.setExtSleep) begin
        toFlag <= 1'b1; pdFlag <= 1'b0;
      end else if (ctl.setWdtRun) begin
        toFlag <= 1'b0; pdFlag <= 1'b1;
      end else if (ctl.setWdtWake) begin
        toFlag <= 1'b0; pdFlag <= 1'b0;
      end else if (ctl.doClrWdt) begin
        toFlag <= 1'b1; pdFlag <= 1'b1;
      end else if (ctl.doSleep) begin
        pdFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl
  import rwc_pkg::*;
#(
  parameter int FILT_LEN      = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int RELEASE_EDGES = 2
) (
  input  logic clk,
  input  logic powerOn,
  input  logic extRstN,
  input  logic wdtExpire,
  input  logic brownOut,
  input  logic sleeping,
  input  logic sleepExec,
  input  logic wdtClear,
  input  logic borSetWr,
  output logic sysRstN,
  output logic wakePulse,
  output logic toFlag,
  output logic pdFlag,
  output logic borFlag
);
  logic     extLow;
  logic     hwClr;
  rwc_ctl_t ctl;

  assign hwClr = powerOn | brownOut;

  rwc_pin_filter #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk(clk), .clr(hwClr), .pinN(extRstN), .pinLow(extLow)
  );

  rwc_ctrl u_ctrl (
    .powerOn(powerOn), .brownOut(brownOut), .extLow(extLow),
    .wdtExpire(wdtExpire), .sleeping(sleeping), .sleepExec(sleepExec),
    .wdtClear(wdtClear), .borSetWr(borSetWr), .ctl(ctl)
  );

  rwc_datapath #(.RELEASE_EDGES(RELEASE_EDGES)) u_dp (
    .clk(clk), .ctl(ctl), .sysRstN(sysRstN), .wakePulse(wakePulse),
    .toFlag(toFlag), .pdFlag(pdFlag), .borFlag(borFlag)
  );
endmodule

// File: rtl/rwc_checker.sv
module rwc_checker (
  input logic clk,
  input logic powerOn,
  input logic brownOut,
  input logic extLow,
  input logic wdtExpire,
  input logic sleeping,
  input logic sleepExec,
  input logic wdtClear,
  input logic borSetWr,
  input logic sysRstN,
  input logic wakePulse,
  input logic toFlag,
  input logic pdFlag,
  input logic borFlag
);
  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (powerOn)
    wakePulse |=> !wakePulse);

  // R7
  wake_no_rst_chk: assert property (@(posedge clk) disable iff (powerOn)
    wakePulse |-> sysRstN);

  // R6
  wdt_run_chk: assert property (@(posedge clk) disable iff (powerOn)
    (wdtExpire && !sleeping && !brownOut) |=> !sysRstN);

  // R2
  bor_evt_chk: assert property (@(posedge clk) disable iff (powerOn)
    brownOut |=> (!borFlag && toFlag && pdFlag && !sysRstN));

  // R4
  ext_run_chk: assert property (@(posedge clk) disable iff (powerOn)
    (extLow && !sleeping && !brownOut) |=> (!sysRstN && $stable(toFlag) && $stable(pdFlag)));

  // R5
  ext_sleep_chk: assert property (@(posedge clk) disable iff (powerOn)
    (extLow && sleeping && !brownOut) |=> (!sysRstN && toFlag && !pdFlag && !wakePulse));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (powerOn)
    $rose(sysRstN) |-> (!brownOut && !$past(brownOut) && !$past(extLow)
                        && !$past(wdtExpire && !sleeping)));

  // R9
  sleep_pd_chk: assert property (@(posedge clk) disable iff (powerOn)
    (sleepExec && !wdtClear && !wdtExpire && !extLow && !brownOut) |=> !pdFlag);

  // R10
  bor_rise_chk: assert property (@(posedge clk) disable iff (powerOn)
    $rose(borFlag) |-> $past(borSetWr || powerOn));
endmodule

bind rst_wake_ctrl rwc_checker u_chk (
  .clk(clk), .powerOn(powerOn), .brownOut(brownOut), .extLow(extLow),
  .wdtExpire(wdtExpire), .sleeping(sleeping), .sleepExec(sleepExec),
  .wdtClear(wdtClear), .borSetWr(borSetWr), .sysRstN(sysRstN),
  .wakePulse(wakePulse), .toFlag(toFlag), .pdFlag(pdFlag), .borFlag(borFlag)
);

// File: tb/sim_rst_wake_ctrl.sv
module sim_rst_wake_ctrl;
  localparam int FILT = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic powerOn = 1'b1, extRstN = 1'b1, wdtExpire = 1'b0, brownOut = 1'b0;
  logic sleeping = 1'b0, sleepExec = 1'b0, wdtClear = 1'b0, borSetWr = 1'b0;
  logic sysRstN, wakePulse, toFlag, pdFlag, borFlag;

  rst_wake_ctrl #(.FILT_LEN(FILT)) u0 (
    .clk(clk), .powerOn(powerOn), .extRstN(extRstN), .wdtExpire(wdtExpire),
    .brownOut(brownOut), .sleeping(sleeping), .sleepExec(sleepExec),
    .wdtClear(wdtClear), .borSetWr(borSetWr), .sysRstN(sysRstN),
    .wakePulse(wakePulse), .toFlag(toFlag), .pdFlag(pdFlag), .borFlag(borFlag)
  );

  typedef struct {
    bit    rst;
    int    wakes;
    bit    to, pd, bor;
    string req;
  } exp_t;

  exp_t  expQ[$];
  exp_t  cur;
  int    nChecks = 0, nFail = 0;
  bit    obsRst = 0;
  int    obsWake = 0;

  task automatic chk(string req, int act, int expv);
    nChecks++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Driver side: push an expected outcome and wait until the monitor takes it
  task automatic expectItem(bit rst, int wakes, bit to, bit pd, bit bor, string req);
    exp_t e;
    e.rst = rst; e.wakes = wakes; e.to = to; e.pd = pd; e.bor = bor; e.req = req;
    expQ.push_back(e);
    wait (expQ.size() == 0);
    tick();
  endtask

  task automatic extPulse(int len);
    extRstN = 1'b0;
    repeat (len) tick();
    extRstN = 1'b1;
    repeat (8) tick();
  endtask

  // Monitor: accumulate observations and compare against the scoreboard
  always @(negedge clk) begin
    if (sysRstN === 1'b0) obsRst = 1'b1;
    if (wakePulse === 1'b1) obsWake++;
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      chk({cur.req, " reset seen"}, int'(obsRst), int'(cur.rst));
      chk({cur.req, " wake count"}, obsWake, cur.wakes);
      chk({cur.req, " sysRstN idle"}, int'(sysRstN), 1);
      chk({cur.req, " toFlag"}, int'(toFlag), int'(cur.to));
      chk({cur.req, " pdFlag"}, int'(pdFlag), int'(cur.pd));
      chk({cur.req, " borFlag"}, int'(borFlag), int'(cur.bor));
      obsRst  = 1'b0;
      obsWake = 0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1 power-on: immediate reset, then release two edges after
    #1;
    chk("R1 async assert", int'(sysRstN), 0);
    repeat (3) tick();
    powerOn = 1'b0;
    tick(); chk("R8 after first edge", int'(sysRstN), 0);
    tick(); chk("R8 after second edge", int'(sysRstN), 1);
    repeat (2) tick();
    expectItem(1, 0, 1, 1, 1, "R1");

    // R9 sleep then watchdog clear
    sleepExec = 1'b1; tick(); sleepExec = 1'b0;
    chk("R9 pd cleared", int'(pdFlag), 0);
    expectItem(0, 0, 1, 0, 1, "R9");
    wdtClear = 1'b1; tick(); wdtClear = 1'b0;
    expectItem(0, 0, 1, 1, 1, "R9");

    // R6 watchdog while running
    wdtExpire = 1'b1; tick(); wdtExpire = 1'b0;
    chk("R6 reset asserted", int'(sysRstN), 0);
    tick(); chk("R8 wdt first edge", int'(sysRstN), 0);
    tick(); chk("R8 wdt second edge", int'(sysRstN), 1);
    expectItem(1, 0, 0, 1, 1, "R6");

    // R2 brown-out
    brownOut = 1'b1; #1;
    chk("R2 async assert", int'(sysRstN), 0);
    repeat (3) tick();
    brownOut = 1'b0;
    tick(); chk("R8 bor first edge", int'(sysRstN), 0);
    tick(); chk("R8 bor second edge", int'(sysRstN), 1);
    expectItem(1, 0, 1, 1, 0, "R2");

    // R10 only a software write re-arms the brown-out flag
    sleepExec = 1'b1; tick(); sleepExec = 1'b0;
    wdtClear = 1'b1; tick(); wdtClear = 1'b0;
    sleepExec = 1'b1; tick(); sleepExec = 1'b0;
    expectItem(0, 0, 1, 0, 0, "R10");
    borSetWr = 1'b1; tick(); borSetWr = 1'b0;
    expectItem(0, 0, 1, 0, 1, "R10");

    // R3 pulse one cycle short of the filter length
    extPulse(FILT - 1);
    expectItem(0, 0, 1, 0, 1, "R3");

    // R4 full-length pulse while running: flags kept
    extPulse(FILT);
    expectItem(1, 0, 1, 0, 1, "R4");

    // R5 pin reset during sleep, starting from to=0 pd=1
    wdtExpire = 1'b1; tick(); wdtExpire = 1'b0;
    repeat (4) tick();
    expectItem(1, 0, 0, 1, 1, "R6");
    sleeping = 1'b1;
    extPulse(FILT);
    sleeping = 1'b0;
    expectItem(1, 0, 1, 0, 1, "R5");

    // R7 watchdog wake from sleep
    wdtClear = 1'b1; tick(); wdtClear = 1'b0;
    sleeping = 1'b1;
    wdtExpire = 1'b1; tick(); wdtExpire = 1'b0;
    chk("R7 wake high", int'(wakePulse), 1);
    chk("R7 no reset", int'(sysRstN), 1);
    tick();
    chk("R7 wake one cycle", int'(wakePulse), 0);
    sleeping = 1'b0;
    expectItem(0, 1, 0, 0, 1, "R7");

    // R11 pin beats watchdog while sleeping
    sleeping = 1'b1;
    extRstN = 1'b0;
    repeat (FILT + 2) tick();
    wdtExpire = 1'b1; tick(); wdtExpire = 1'b0;
    tick();
    extRstN = 1'b1;
    repeat (8) tick();
    sleeping = 1'b0;
    expectItem(1, 0, 1, 0, 1, "R11");

    // R11 brown-out beats running watchdog
    brownOut = 1'b1; wdtExpire = 1'b1; tick();
    brownOut = 1'b0; wdtExpire = 1'b0;
    repeat (4) tick();
    expectItem(1, 0, 1, 1, 0, "R11");

    // R11 power-on beats brown-out
    powerOn = 1'b1; brownOut = 1'b1;
    repeat (3) tick();
    powerOn = 1'b0; brownOut = 1'b0;
    repeat (4) tick();
    expectItem(1, 0, 1, 1, 1, "R11");

    tick();
    summary();
    $finish;
  end
endmodule